// File: doc/BRIEF.md
# Extended-Precision Add Step with Condition Flags

This block performs one step of a multi-precision addition. It adds a source operand, a destination operand and the incoming extend bit. The operand size is byte, word or long. Only the low bits of the selected width take the sum. The bits of the destination above that width pass through to the result unchanged. This lets a chain of these steps build an add of any length, where each step takes its carry from the extend bit left by the step before.

When a one-cycle strobe is asserted, the block registers the merged 32-bit result and a new flag set. The flag set holds extend, negative, zero, overflow and carry. The zero flag is sticky across a chain. A zero step result keeps the incoming zero flag, and a nonzero step result clears it. After a chain, zero is therefore set only if every step gave zero. Between strobes, and on an illegal size code, the outputs hold their values.

Top module: `xadd_step`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o` becomes 0 and `flags_o` becomes 0.
- R2: With `size_i` = 00 (byte), `result_o[7:0]` is the 8-bit sum and `result_o[31:8]` equals `dst_i[31:8]`.
- R3: With `size_i` = 01 (word), `result_o[15:0]` is the 16-bit sum and `result_o[31:16]` equals `dst_i[31:16]`.
- R4: With `size_i` = 10 (long), `result_o` is the 32-bit sum of `dst_i`, `src_i` and the carry-in.
- R5: The carry-in is `x_i`. When `x_i` is 1, the sized sum is dst + src + 1. When `x_i` is 0, it is dst + src.
- R6: `flags_o[4]` (extend) and `flags_o[0]` (carry) both equal the carry out of the selected width.
- R7: `flags_o[2]` (zero) equals `z_i` when the sized result is zero, and is 0 otherwise. It is never set by a step.
- R8: `flags_o[3]` (negative) is the top bit of the sized result.
- R9: `flags_o[1]` (overflow) is 1 when the two operands share a sign bit at the selected width and the sized result has the other sign.
- R10: A strobe with `size_i` = 11 leaves `result_o` and `flags_o` unchanged.
- R11: With `valid_i` low, `result_o` and `flags_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | One-cycle strobe that starts an add step |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 10 long, 11 illegal |
| dst_i | input | 32 | Destination operand; upper bits are kept in the result |
| src_i | input | 32 | Source operand |
| x_i | input | 1 | Incoming extend flag, used as the carry-in |
| z_i | input | 1 | Incoming zero flag, for the sticky zero rule |
| result_o | output | 32 | Registered merged result |
| flags_o | output | 5 | Registered flags {X, N, Z, V, C}, bit 4 down to bit 0 |

## Verification
Directed operands are chosen to separate each flag rule:
- An all-ones plus one with a clear carry-in wraps to zero. With the extend bit set, it wraps to one. This shows the two carry-detection cases apart.
- Zero and nonzero results are driven with the incoming zero flag both set and clear. This exposes a zero flag that is set rather than only kept.
- Sign-boundary operands such as largest positive plus one show overflow and negative at each of the three widths.
- Destinations with distinctive upper bits show whether the merge keeps the right bits.

A long run of random operands, sizes and incoming flags, mixed with idle cycles and illegal size codes, is then compared with a behavioural model on every clock.

// File: rtl/xadd_pkg.sv
package xadd_pkg;

    localparam int DW     = 32;
    localparam int NLANE  = 3;
    localparam int NFLAGS = 5;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [DW-1:0] merged;
        logic          zero;
        logic          cout;
        logic          dsign;
        logic          ssign;
        logic          rsign;
    } lane_out_t;

    function automatic int lane_width(int k);
        return 8 << k;
    endfunction

    function automatic logic [DW-1:0] size_mask(size_e s);
        logic [DW-1:0] m;
        case (s)
            SZ_BYTE: m = {{(DW-8){1'b0}}, 8'hFF};
            SZ_WORD: m = {{(DW-16){1'b0}}, 16'hFFFF};
            default: m = {DW{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xadd_lanes.sv
module xadd_lanes
    import xadd_pkg::*;
(
    input  logic [DW-1:0]             dst_i,
    input  logic [DW-1:0]             src_i,
    input  logic                      cin_i,
    output logic [NLANE-1:0][DW-1:0]  sum_o,
    output logic [NLANE-1:0]          cout_o,
    output logic [NLANE-1:0]          dsign_o,
    output logic [NLANE-1:0]          ssign_o,
    output logic [NLANE-1:0]          rsign_o
);

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        localparam int W = lane_width(k);
        logic [W:0] wide;

        assign wide = {1'b0, dst_i[W-1:0]} + {1'b0, src_i[W-1:0]}
                    + {{W{1'b0}}, cin_i};

        if (W < DW) begin : g_pad
            assign sum_o[k] = {{(DW-W){1'b0}}, wide[W-1:0]};
        end else begin : g_full
            assign sum_o[k] = wide[W-1:0];
        end

        assign cout_o[k]  = wide[W];
        assign dsign_o[k] = dst_i[W-1];
        assign ssign_o[k] = src_i[W-1];
        assign rsign_o[k] = wide[W-1];
    end

endmodule

// File: rtl/xadd_select.sv
module xadd_select
    import xadd_pkg::*;
(
    input  size_e                     size_i,
    input  logic [DW-1:0]             dst_i,
    input  logic [NLANE-1:0][DW-1:0]  sum_i,
    input  logic [NLANE-1:0]          cout_i,
    input  logic [NLANE-1:0]          dsign_i,
    input  logic [NLANE-1:0]          ssign_i,
    input  logic [NLANE-1:0]          rsign_i,
    output lane_out_t                 lane_o
);

    logic [1:0]    idx;
    logic [DW-1:0] mask;
    logic [DW-1:0] picked;

    always_comb begin
        idx    = (size_i == SZ_BAD) ? 2'd2 : size_i;
        mask   = size_mask(size_i);
        picked = sum_i[idx];

        lane_o.merged = (dst_i & ~mask) | (picked & mask);
        lane_o.zero   = (picked == '0);
        lane_o.cout   = cout_i[idx];
        lane_o.dsign  = dsign_i[idx];
        lane_o.ssign  = ssign_i[idx];
        lane_o.rsign  = rsign_i[idx];
    end

endmodule

// File: rtl/xadd_flags.sv
module xadd_flags
    import xadd_pkg::*;
(
    input  lane_out_t lane_i,
    input  logic      z_i,
    output ccr_t      ccr_o
);

    always_comb begin
        ccr_o.x = lane_i.cout;
        ccr_o.c = lane_i.cout;
        ccr_o.n = lane_i.rsign;
        ccr_o.z = lane_i.zero & z_i;
        ccr_o.v = (lane_i.dsign == lane_i.ssign) && (lane_i.rsign != lane_i.dsign);
    end

endmodule

// File: rtl/xadd_step.sv
module xadd_step
    import xadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [1:0]        size_i,
    input  logic [DW-1:0]     dst_i,
    input  logic [DW-1:0]     src_i,
    input  logic              x_i,
    input  logic              z_i,
    output logic [DW-1:0]     result_o,
    output logic [NFLAGS-1:0] flags_o
);

    size_e                    size_s;
    logic [NLANE-1:0][DW-1:0] lane_sum;
    logic [NLANE-1:0]         lane_cout;
    logic [NLANE-1:0]         lane_dsign;
    logic [NLANE-1:0]         lane_ssign;
    logic [NLANE-1:0]         lane_rsign;
    lane_out_t                lane_pick;
    ccr_t                     ccr_next;
    ccr_t                     ccr_q;
    logic [DW-1:0]            result_q;
    logic                     take;

    assign size_s = size_e'(size_i);
    assign take   = valid_i && (size_s != SZ_BAD);

    xadd_lanes u_lanes (
        .dst_i   (dst_i),
        .src_i   (src_i),
        .cin_i   (x_i),
        .sum_o   (lane_sum),
        .cout_o  (lane_cout),
        .dsign_o (lane_dsign),
        .ssign_o (lane_ssign),
        .rsign_o (lane_rsign)
    );

    xadd_select u_select (
        .size_i  (size_s),
        .dst_i   (dst_i),
        .sum_i   (lane_sum),
        .cout_i  (lane_cout),
        .dsign_i (lane_dsign),
        .ssign_i (lane_ssign),
        .rsign_i (lane_rsign),
        .lane_o  (lane_pick)
    );

    xadd_flags u_flags (
        .lane_i (lane_pick),
        .z_i    (z_i),
        .ccr_o  (ccr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            ccr_q    <= '0;
        end else if (take) begin
            result_q <= lane_pick.merged;
            ccr_q    <= ccr_next;
        end
    end

    assign result_o = result_q;
    assign flags_o  = ccr_q;

endmodule

// File: rtl/xadd_step_chk.sv
module xadd_step_chk
    import xadd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [1:0]        size_i,
    input logic [DW-1:0]     dst_i,
    input logic              z_i,
    input logic [DW-1:0]     result_o,
    input logic [NFLAGS-1:0] flags_o
);

    logic legal;
    assign legal = (size_i != 2'b11);

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(flags_o)));

    p_hold_illegal_r10: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !legal) |=> ($stable(result_o) && $stable(flags_o)));

    p_x_matches_c_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && legal) |=> (flags_o[4] == flags_o[0]));

    p_z_never_set_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && legal && !z_i) |=> !flags_o[2]);

    p_byte_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && size_i == 2'b00) |=> (result_o[31:8] == $past(dst_i[31:8])));

    p_word_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && size_i == 2'b01) |=> (result_o[31:16] == $past(dst_i[31:16])));

endmodule

bind xadd_step xadd_step_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (valid_i),
    .size_i   (size_i),
    .dst_i    (dst_i),
    .z_i      (z_i),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/xadd_step_tb.sv
module xadd_step_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [1:0]  size_i;
    logic [31:0] dst_i;
    logic [31:0] src_i;
    logic        x_i;
    logic        z_i;
    logic [31:0] result_o;
    logic [4:0]  flags_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] exp_res;
    logic [4:0]  exp_flg;

    always #(CLK_PERIOD/2) clk = ~clk;

    xadd_step u_dut (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_i),
        .size_i   (size_i),
        .dst_i    (dst_i),
        .src_i    (src_i),
        .x_i      (x_i),
        .z_i      (z_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    // behavioural reference, updated once per rising edge
    task automatic model(input bit v, input bit r, input logic [1:0] sz,
                         input logic [31:0] d, input logic [31:0] s,
                         input bit xin, input bit zin);
        longint w, mask, a, b, sum, res;
        bit cy, n, z, ov, sa, sb;
        if (r) begin
            exp_res = 0;
            exp_flg = 0;
            return;
        end
        if (!v || sz == 2'b11) return;
        w    = 8 * (1 << sz);
        mask = (longint'(1) << w) - 1;
        a    = longint'(d) & mask;
        b    = longint'(s) & mask;
        sum  = a + b + (xin ? 1 : 0);
        res  = sum & mask;
        cy   = ((sum >> w) & 1) != 0;
        n    = ((res >> (w - 1)) & 1) != 0;
        sa   = ((a >> (w - 1)) & 1) != 0;
        sb   = ((b >> (w - 1)) & 1) != 0;
        ov   = (sa == sb) && (n != sa);
        z    = (res == 0) ? zin : 1'b0;
        exp_res = 32'((longint'(d) & ~mask) | res);
        exp_flg = {cy, n, z, ov, cy};
    endtask

    task automatic compare(input string tag);
        checks++;
        if (result_o !== exp_res) begin
            errors++;
            $display("FAIL %s result actual %h expected %h", tag, result_o, exp_res);
        end
        checks++;
        if (flags_o !== exp_flg) begin
            errors++;
            $display("FAIL %s flags actual %b expected %b", tag, flags_o, exp_flg);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] sz, input logic [31:0] d,
                        input logic [31:0] s, input bit xin, input bit zin,
                        input string tag);
        @(negedge clk);
        valid_i = v; size_i = sz; dst_i = d; src_i = s; x_i = xin; z_i = zin;
        @(posedge clk);
        model(v, rst, sz, d, s, xin, zin);
        @(negedge clk);
        compare(tag);
        valid_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_i = 1'b1; size_i = 2'b10;
        dst_i = 32'hFFFF_FFFF; src_i = 32'h1; x_i = 1'b1; z_i = 1'b1;
        exp_res = 0; exp_flg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset");
        rst = 1'b0; valid_i = 1'b0;

        // byte: carry with clear X, zero result keeps Z
        step(1, 2'b00, 32'hABCD_12FF, 32'h0000_0001, 0, 1, "R2 R6 R7 byte wrap");
        // byte: set X, 0xFF+0x00+1 wraps, Z input clear stays clear
        step(1, 2'b00, 32'h5555_55FF, 32'h0000_0000, 1, 0, "R5 R6 R7 byte xin");
        // byte overflow 0x7F+0x01
        step(1, 2'b00, 32'h1234_567F, 32'hFFFF_FF01, 0, 1, "R8 R9 byte overflow");
        // byte: nonzero result clears Z
        step(1, 2'b00, 32'h0000_0010, 32'h0000_0020, 0, 1, "R7 byte nonzero");
        // word
        step(1, 2'b01, 32'hDEAD_FFFF, 32'h0000_0001, 1, 1, "R3 R5 word xin");
        step(1, 2'b01, 32'hCAFE_8000, 32'h0001_8000, 0, 1, "R3 R9 word negative overflow");
        step(1, 2'b01, 32'hCAFE_FFFF, 32'hBEEF_0001, 0, 1, "R3 R7 word zero sticky");
        // long
        step(1, 2'b10, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, "R4 R8 R9 long overflow");
        step(1, 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, "R4 R5 R6 long carry");
        step(1, 2'b10, 32'hFFFF_FFFF, 32'h0000_0000, 1, 1, "R4 R6 R7 long xin zero");
        // illegal size and idle
        step(1, 2'b11, 32'h1111_1111, 32'h2222_2222, 1, 0, "R10 illegal size");
        step(0, 2'b10, 32'h3333_3333, 32'h4444_4444, 0, 1, "R11 idle");

        // random mix compared each clock
        for (int i = 0; i < 600; i++) begin
            logic [1:0] sz;
            bit v;
            sz = 2'($urandom_range(0, 3));
            v  = ($urandom_range(0, 5) != 0);
            step(v, sz, $urandom, ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom,
                 1'($urandom), 1'($urandom),
                 (!v) ? "R11 random idle" : (sz == 2'b11) ? "R10 random illegal" :
                 (sz == 2'b00) ? "R2 random byte" : (sz == 2'b01) ? "R3 random word" :
                 "R4 random long");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule